// File: doc/BRIEF.md
# Word-Serial Montgomery Multiplier Without Final Subtraction

This block computes the Montgomery product S = A·B·2^(-P·T) mod N. The operands A and B and the modulus N are each P words of T bits. The block takes one T-bit word of A per outer iteration, starting from the least significant word. The constant nprime, which satisfies n_0·nprime ≡ −1 (mod 2^T) for the low word n_0 of N, is computed by the caller and fed in. The result is left unreduced: it is congruent to the true product and stays below 2N, so it can feed straight back in as an operand in a modular exponentiation chain.

A one-cycle `start` loads all operands in parallel. Each iteration takes two clock cycles. The first cycle forms the quotient digit q = (s_0 + a_i·b_0)·nprime mod 2^T. The second cycle adds a_i·B + q·N into the accumulator and shifts the sum right by one word. The block never compares the result against N, so the cycle count is the same for every operand value. `done` pulses for one cycle once the result is valid. The caller must size P with one spare word, so that N < 2^((P−1)·T).

Top module: `mont_ws_nosub`

## Requirements
- R1: When `done` pulses, `s_out`·2^(P·T) ≡ A·B (mod N) for the operands loaded at the accepted `start`. Every word update leaves a sum whose low T bits are zero.
- R2: If N is odd, N < 2^((P−1)·T), A < 2N and B < 2N, then `s_out` < 2N when `done` pulses.
- R3: Under the conditions of R2, the sum S + a_i·B + q·N never needs more than P·T + T bits, so the accumulator never overflows.
- R4: `done` goes high exactly 2·P clock edges after the edge that accepts `start`, whatever the data, and stays high for exactly one cycle.
- R5: `busy` is high from the edge that accepts `start` until the edge that raises `done`. `busy` and `done` are never high together.
- R6: A `start` that arrives while `busy` is high is ignored. The running operation keeps its operands, its result and its timing.
- R7: After `done`, `s_out` keeps the result until the next `start` is accepted.
- R8: After reset, `busy`, `done` and `s_out` are all zero.
- R9: No final subtraction is made. `s_out` equals the exact value of the word-serial recurrence (S cleared, then S ← (S + a_i·B + q_i·N)/2^T for i = 0..P−1), even when that value is N or larger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load the operands and begin; ignored while busy |
| a_in | input | P·T | Multiplier A, below 2N |
| b_in | input | P·T | Multiplicand B, below 2N |
| n_in | input | P·T | Odd modulus N, below 2^((P−1)·T) |
| nprime | input | T | −N^(−1) mod 2^T |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| s_out | output | P·T | Unreduced Montgomery product |

## Verification
The block is tried with moduli of every size, from the smallest odd value (1) up to the largest value the spare-word rule allows. Both operands are pushed to 2N−1, which stresses the overflow bound and the below-2N bound. A zero operand shows that the quotient path settles without leaking state between runs. Unit and near-modulus operands separate the effect of the shift from the effect of the reduction. Seeded random legal triples compare the output exactly against the recurrence, which catches any silent reduction. A second `start` injected mid-run checks that the running operation is isolated.

// File: rtl/mont_ws_nosub.sv
module mont_ws_nosub #(
  parameter int T = 16,
  parameter int P = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [P*T-1:0] a_in,
  input  logic [P*T-1:0] b_in,
  input  logic [P*T-1:0] n_in,
  input  logic [T-1:0]   nprime,
  output logic           busy,
  output logic           done,
  output logic [P*T-1:0] s_out
);
  localparam int W    = P * T;
  localparam int ACCW = W + T + 2;
  localparam int IW   = $clog2(P + 1);
  localparam int CW   = $clog2(2 * P + 2);

  logic [W-1:0]  a_q, b_q, n_q, s_q;
  logic [T-1:0]  np_q, q_q;
  logic [IW-1:0] idx_q;
  logic          ph_q, busy_q, done_q;

  logic [T-1:0]    qsum, q_next;
  logic [ACCW-1:0] acc_sum;

  assign qsum    = s_q[T-1:0] + a_q[T-1:0] * b_q[T-1:0];
  assign q_next  = qsum * np_q;
  assign acc_sum = ACCW'(s_q) + ACCW'(a_q[T-1:0]) * ACCW'(b_q) + ACCW'(q_q) * ACCW'(n_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; n_q <= '0; s_q <= '0;
      np_q <= '0; q_q <= '0; idx_q <= '0;
      ph_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          a_q    <= a_in;
          b_q    <= b_in;
          n_q    <= n_in;
          np_q   <= nprime;
          s_q    <= '0;
          idx_q  <= '0;
          ph_q   <= 1'b0;
          busy_q <= 1'b1;
        end
      end else if (!ph_q) begin
        q_q  <= q_next;
        ph_q <= 1'b1;
      end else begin
        s_q   <= acc_sum[W+T-1:T];
        a_q   <= a_q >> T;
        ph_q  <= 1'b0;
        idx_q <= idx_q + 1'b1;
        if (idx_q == IW'(P - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign s_out = s_q;

  logic [CW-1:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cyc_q <= '0;
    else if (!busy_q && start) cyc_q <= '0;
    else if (busy_q)          cyc_q <= cyc_q + 1'b1;
  end

  AST_LOW_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && ph_q |-> acc_sum[T-1:0] == '0);                              // R1
  AST_BELOW_2N: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> {1'b0, s_q} < ({1'b0, n_q} << 1));                           // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && ph_q |-> acc_sum[ACCW-1:W+T] == '0);                          // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);                                                    // R4
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> cyc_q == CW'(2 * P));                                        // R4
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);                                                    // R5
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start |=> $stable(b_q) && $stable(n_q) && $stable(np_q));     // R6
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && !start |=> $stable(s_q));                                    // R7
endmodule

// File: tb/mont_ws_nosub_bench.sv
module mont_ws_nosub_bench;
  localparam int T = 4;
  localparam int P = 5;
  localparam int W = P * T;
  localparam int NV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0, n_in = '0;
  logic [T-1:0] nprime = '0;
  logic busy, done;
  logic [W-1:0] s_out;

  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;

  mont_ws_nosub #(.T(T), .P(P)) u_mont_ws_nosub (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
    .n_in(n_in), .nprime(nprime), .busy(busy), .done(done), .s_out(s_out));

  // {N, A, B}: max corner, tiny, N=1, zero operand, misc
  localparam longint VN[NV] = '{65535, 3, 1, 50001, 40961, 12345, 65521, 7777};
  localparam longint VA[NV] = '{131069, 5, 1, 0, 81921, 24000, 1, 15000};
  localparam longint VB[NV] = '{131069, 5, 1, 12345, 2, 17, 65520, 15553};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint inv_neg(input longint n);
    for (int x = 0; x < (1 << T); x++)
      if (((n * x + 1) & ((1 << T) - 1)) == 0) return x;
    return 0;
  endfunction

  function automatic longint model(input longint a, input longint b, input longint n);
    longint s = 0, ai, q, msk = (1 << T) - 1, np = inv_neg(n);
    for (int i = 0; i < P; i++) begin
      ai = (a >> (i * T)) & msk;
      q  = (((s + ai * b) & msk) * np) & msk;
      s  = (s + ai * b + q * n) >> T;
    end
    return s;
  endfunction

  task automatic run_op(input longint a, input longint b, input longint n, input int inject_at);
    longint exp = model(a, b, n);
    int cyc = 0;
    int busy_bad = 0;
    longint res;
    @(negedge clk);
    a_in = W'(a); b_in = W'(b); n_in = W'(n); nprime = T'(inv_neg(n)); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 1000) begin
      if (!busy) busy_bad++;
      if (cyc == inject_at) begin
        a_in = W'(7); b_in = W'(9); n_in = W'(11); nprime = T'(inv_neg(11)); start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    res = longint'(s_out);
    chk(cyc == 2 * P, "R4 latency", cyc, 2 * P);
    chk(busy_bad == 0 && !busy, "R5 busy span", busy_bad, 0);
    chk(res == exp, inject_at >= 0 ? "R6/R9 exact result" : "R9 exact result", res, exp);
    chk(((res << W) % n) == ((a * b) % n), "R1 congruence", (res << W) % n, (a * b) % n);
    chk(res < 2 * n, "R2/R3 below 2N", res, 2 * n);
    @(negedge clk);
    chk(!done, "R4 one-cycle done", done, 0);
    a_in = '1; b_in = '1;
    repeat (3) @(negedge clk);
    chk(longint'(s_out) == exp, "R7 hold", longint'(s_out), exp);
  endtask

  initial begin
    #3;
    chk(busy == 1'b0 && done == 1'b0 && s_out == '0, "R8 reset", {busy, done, s_out}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk(busy == 1'b0 && done == 1'b0 && s_out == '0, "R8 after release", {busy, done, s_out}, 0);
    for (int v = 0; v < NV; v++) run_op(VA[v], VB[v], VN[v], -1);
    run_op(VA[0], VB[0], VN[0], 3);
    run_op(VA[6], VB[6], VN[6], 2 * P - 1);
    for (int k = 0; k < 20; k++) begin
      longint n, a, b;
      n = longint'($urandom_range(65535, 1)) | 1;
      a = longint'($urandom) % (2 * n);
      b = longint'($urandom) % (2 * n);
      run_op(a, b, n, -1);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule